// File: doc/BRIEF.md
# Clause 22/45 MDIO Management Master

This block lets a host reach the management registers of Ethernet PHYs over a two-wire serial link. The host sees four 32-bit registers, selected by a 2-bit index: configuration/status, command, data and address. Writing these registers is what launches serial frames. A frame carries either Clause 22 or Clause 45 framing. A single bit in the configuration register picks the format.

Three kinds of frame exist. An address frame (Clause 45 only) starts when the address register is written. A write frame starts when the data register is written. A read frame starts when the command register is written with its read bit set. The block divides the system clock down to make the management clock, `mdc`. It drives the serial data line through a separate output and output-enable pair, so the tristate buffer stays outside the block. While a frame is on the line, a busy flag is raised. When a read finds no PHY answering, a sticky error flag is set.

The command register also stores a scan bit and an auto-increment bit. Both can be read back, but they have no effect on frames.

Top module: `mdio_master`

## Requirements
- R1: Reset clears every register. Index 0 (status) reads busy at bit 0, read error at bit 1, Clause-45 select at bit 6 and the 8-bit divider at bits 15:8. Index 1 (command) holds the device/register field at 4:0, the PHY field at 9:5, preamble-off at 10, scan at 11 and auto-increment at 14; the read bit 15 always reads back 0. Index 2 (data) holds data at 15:0 and a copy of busy at bit 31. Index 3 (address) holds the 16-bit address at 15:0.
- R2: While a frame runs, `mdc` has a period of 2×D system clocks, where D is the divider field and a field of 0 acts as 1. While idle, `mdc` is low.
- R3: A frame begins with 32 one bits unless preamble-off is set, in which case the preamble is left out. The frame body follows, most significant bit first: start (2), op (2), PHY (5), device/register (5), turnaround (2), data (16). `mdio_o` changes only while `mdc` is low, so it is stable at each rising edge.
- R4: With Clause-45 select clear, the start code is 01, a write uses op 01, a read uses op 10, and the device/register field is the 5-bit register number.
- R5: With Clause-45 select set, a write to the address register launches a frame with start 00 and op 00, whose 16 data bits are the written address.
- R6: A write to the data register launches a write frame. It carries the stored PHY and device fields, turnaround 10, and the written 16-bit value. In Clause 45 the op is 01.
- R7: A command write with bit 15 set launches a read frame; in Clause 45 the op is 11. `mdio_oe` drops at the first turnaround bit and stays low to the end of the frame. The 16 bits sampled on the rising `mdc` edges of the data field land in data bits 15:0, first bit at bit 15.
- R8: If the line is high at the rising edge of the second turnaround bit of a read, the read-error bit is set. The bit stays set through later frames until the next read frame is launched, and that launch clears it.
- R9: Busy rises at the clock edge that accepts a launching write. It falls at the falling `mdc` edge that ends the last bit. It shows both in status bit 0 and in data bit 31.
- R10: While busy, register writes of every kind are ignored. No frame is launched and no stored field changes.
- R11: A write to the address register while Clause-45 select is clear stores the value and launches nothing.
- R12: `mdio_oe` is low whenever no frame is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wr_sel | input | 2 | Register index for the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 2 | Register index for readback |
| reg_rd_data | output | 32 | Readback value of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Serial data from the line (pulled up externally) |

## Verification
On every cycle, the assertions check these properties:
- `mdc` and `mdio_oe` stay quiet while idle.
- The data line never changes while `mdc` is high.
- Busy only rises after a register write.
- The read-error flag only rises during a frame.
- The divider never moves under a write made while busy.

The bench's scenarios cover what a per-cycle property cannot express:
- The exact bit sequences of address, write and read frames in both formats, with and without preamble.
- The measured `mdc` period for several divider values.
- Capture of the PHY's read data.
- The error flag staying set across a later write, then clearing when the next read launches.
- Writes made while busy leaving no trace once the frame has finished.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int DIV_W   = 8;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int PRE_LEN = 32;
    localparam int FRAME_W = 2 + 2 + ADDR_W + ADDR_W + 2 + DATA_W;

    // register indices
    localparam logic [1:0] SEL_STAT = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam logic [1:0] SEL_ADDR = 2'd3;

    // field positions
    localparam int ST_BUSY   = 0;
    localparam int ST_RDERR  = 1;
    localparam int ST_C45    = 6;
    localparam int ST_DIV_LO = 8;
    localparam int CT_PORT_LO = 5;
    localparam int CT_PREOFF  = 10;
    localparam int CT_SCAN    = 11;
    localparam int CT_AUTOINC = 14;
    localparam int CT_READ    = 15;
    localparam int DT_BUSY    = 31;

    localparam logic [1:0] START_C22 = 2'b01;
    localparam logic [1:0] START_C45 = 2'b00;
    localparam logic [1:0] OP_ADDR   = 2'b00;
    localparam logic [1:0] OP_WRITE  = 2'b01;
    localparam logic [1:0] OP_RD22   = 2'b10;
    localparam logic [1:0] OP_RD45   = 2'b11;
    localparam logic [1:0] TA_DRIVE  = 2'b10;

    typedef struct packed {
        logic [1:0]        st;
        logic [1:0]        op;
        logic [ADDR_W-1:0] port;
        logic [ADDR_W-1:0] dev;
        logic [DATA_W-1:0] payload;
        logic              pre_off;
        logic              is_read;
    } frame_req_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } clk_state_t;

    clk_state_t s_d, s_q;
    logic [DIV_W-1:0] half;

    always_comb begin
        half = (div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div;
        s_d  = s_q;
        rise = 1'b0;
        fall = 1'b0;
        if (!run) begin
            s_d = '0;
        end else if (s_q.cnt == half - 1'b1) begin
            s_d.cnt = '0;
            s_d.mdc = !s_q.mdc;
            rise    = !s_q.mdc;
            fall    = s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc = s_q.mdc;

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  frame_req_t        req,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic              err_set,
    output logic [DATA_W-1:0] rd_data
);

    localparam int CNT_W = $clog2(PRE_LEN + FRAME_W);
    localparam int IDX_W = $clog2(FRAME_W);

    typedef struct packed {
        logic               busy;
        logic               is_read;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] word;
        logic [DATA_W-1:0]  rx;
    } eng_state_t;

    eng_state_t s_d, s_q;
    logic       done;

    always_comb begin
        s_d     = s_q;
        done    = 1'b0;
        err_set = 1'b0;
        if (start && !s_q.busy) begin
            s_d.busy    = 1'b1;
            s_d.is_read = req.is_read;
            s_d.word    = {req.st, req.op, req.port, req.dev, TA_DRIVE, req.payload};
            s_d.cnt     = req.pre_off ? CNT_W'(FRAME_W - 1) : CNT_W'(PRE_LEN + FRAME_W - 1);
            s_d.rx      = '0;
        end else if (s_q.busy) begin
            if (rise && s_q.is_read) begin
                if (s_q.cnt < CNT_W'(DATA_W))
                    s_d.rx = {s_q.rx[DATA_W-2:0], mdio_i};
                if (s_q.cnt == CNT_W'(DATA_W))
                    err_set = mdio_i;
            end
            if (fall) begin
                if (s_q.cnt == '0) begin
                    s_d.busy = 1'b0;
                    done     = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign mdio_o  = s_q.busy & ((s_q.cnt >= CNT_W'(FRAME_W)) | s_q.word[s_q.cnt[IDX_W-1:0]]);
    assign mdio_oe = s_q.busy & !(s_q.is_read && (s_q.cnt <= CNT_W'(DATA_W + 1)));
    assign rd_done = done & s_q.is_read;
    assign rd_data = s_q.rx;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_wr_sel,
    input  logic [31:0] reg_wr_data,
    input  logic [1:0]  reg_rd_sel,
    output logic [31:0] reg_rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    typedef struct packed {
        logic              c45;
        logic [DIV_W-1:0]  div;
        logic [ADDR_W-1:0] dev;
        logic [ADDR_W-1:0] port;
        logic              pre_off;
        logic              scan;
        logic              auto_inc;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] addr;
        logic              rd_err;
    } regs_t;

    regs_t             s_d, s_q;
    frame_req_t        req;
    logic              start;
    logic              busy;
    logic              tick_rise, tick_fall;
    logic              rd_done, err_set;
    logic [DATA_W-1:0] rx_data;
    logic [DIV_W-1:0]  cfg_div;
    logic              rd_err_flag;
    logic              unused_hi_bits;

    assign unused_hi_bits = ^reg_wr_data[31:16];
    assign cfg_div        = s_q.div;
    assign rd_err_flag    = s_q.rd_err;

    always_comb begin
        s_d         = s_q;
        start       = 1'b0;
        req         = '0;
        req.st      = s_q.c45 ? START_C45 : START_C22;
        req.port    = s_q.port;
        req.dev     = s_q.dev;
        req.pre_off = s_q.pre_off;
        if (reg_wr && !busy) begin
            unique case (reg_wr_sel)
                SEL_STAT: begin
                    s_d.c45 = reg_wr_data[ST_C45];
                    s_d.div = reg_wr_data[ST_DIV_LO +: DIV_W];
                end
                SEL_CTRL: begin
                    s_d.dev      = reg_wr_data[ADDR_W-1:0];
                    s_d.port     = reg_wr_data[CT_PORT_LO +: ADDR_W];
                    s_d.pre_off  = reg_wr_data[CT_PREOFF];
                    s_d.scan     = reg_wr_data[CT_SCAN];
                    s_d.auto_inc = reg_wr_data[CT_AUTOINC];
                    if (reg_wr_data[CT_READ]) begin
                        start       = 1'b1;
                        req.is_read = 1'b1;
                        req.op      = s_q.c45 ? OP_RD45 : OP_RD22;
                        req.port    = reg_wr_data[CT_PORT_LO +: ADDR_W];
                        req.dev     = reg_wr_data[ADDR_W-1:0];
                        req.pre_off = reg_wr_data[CT_PREOFF];
                        s_d.rd_err  = 1'b0;
                    end
                end
                SEL_DATA: begin
                    s_d.data    = reg_wr_data[DATA_W-1:0];
                    start       = 1'b1;
                    req.op      = OP_WRITE;
                    req.payload = reg_wr_data[DATA_W-1:0];
                end
                SEL_ADDR: begin
                    s_d.addr    = reg_wr_data[DATA_W-1:0];
                    start       = s_q.c45;
                    req.op      = OP_ADDR;
                    req.payload = reg_wr_data[DATA_W-1:0];
                end
                default: ;
            endcase
        end
        if (rd_done) s_d.data   = rx_data;
        if (err_set) s_d.rd_err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rd_data = '0;
        unique case (reg_rd_sel)
            SEL_STAT: begin
                reg_rd_data[ST_BUSY]              = busy;
                reg_rd_data[ST_RDERR]             = s_q.rd_err;
                reg_rd_data[ST_C45]               = s_q.c45;
                reg_rd_data[ST_DIV_LO +: DIV_W]   = s_q.div;
            end
            SEL_CTRL: begin
                reg_rd_data[ADDR_W-1:0]           = s_q.dev;
                reg_rd_data[CT_PORT_LO +: ADDR_W] = s_q.port;
                reg_rd_data[CT_PREOFF]            = s_q.pre_off;
                reg_rd_data[CT_SCAN]              = s_q.scan;
                reg_rd_data[CT_AUTOINC]           = s_q.auto_inc;
            end
            SEL_DATA: begin
                reg_rd_data[DATA_W-1:0]           = s_q.data;
                reg_rd_data[DT_BUSY]              = busy;
            end
            SEL_ADDR: reg_rd_data[DATA_W-1:0]     = s_q.addr;
            default: ;
        endcase
    end

    mdio_clkgen #(.DIV_W(DIV_W)) i_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .div  (s_q.div),
        .mdc  (mdc),
        .rise (tick_rise),
        .fall (tick_fall)
    );

    mdio_frame i_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .req    (req),
        .rise   (tick_rise),
        .fall   (tick_fall),
        .mdio_i (mdio_i),
        .busy   (busy),
        .mdio_o (mdio_o),
        .mdio_oe(mdio_oe),
        .rd_done(rd_done),
        .err_set(err_set),
        .rd_data(rx_data)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       busy,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe,
    input logic       rd_err,
    input logic [7:0] cfg_div
);

    // R12
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    // R2
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R3
    stable_at_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_o));

    // R9
    launch_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr));

    // R8
    err_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_err) |-> $past(busy));

    // R10
    frozen_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr) |=> $stable(cfg_div));

endmodule

bind mdio_master mdio_master_chk i_mdio_master_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .reg_wr (reg_wr),
    .busy   (busy),
    .mdc    (mdc),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe),
    .rd_err (rd_err_flag),
    .cfg_div(cfg_div)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_wr_sel = 2'd0;
    logic [31:0] reg_wr_data = '0;
    logic [1:0]  reg_rd_sel = 2'd0;
    logic [31:0] reg_rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    logic        cap_o  [0:79];
    logic        cap_oe [0:79];
    int          cap_n = 0;
    time         rise_t [0:1];
    logic        phy_on = 1'b0;
    logic [15:0] phy_resp = '0;
    int          phy_pre = 32;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master i_mdio_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wr_sel (reg_wr_sel),
        .reg_wr_data(reg_wr_data),
        .reg_rd_sel (reg_rd_sel),
        .reg_rd_data(reg_rd_data),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .mdio_i     (mdio_i)
    );

    // PHY model: frame position p counts from the first start bit
    function automatic logic phy_bit(int k);
        int p;
        p = k - phy_pre;
        if (!phy_on) return 1'b1;
        if (p == 15) return 1'b0;
        if (p >= 16 && p <= 31) return phy_resp[31 - p];
        return 1'b1;
    endfunction

    always @(posedge mdc) begin
        if (cap_n < 2) rise_t[cap_n] = $time;
        if (cap_n < 80) begin
            cap_o[cap_n]  = mdio_o;
            cap_oe[cap_n] = mdio_oe;
        end
        cap_n = cap_n + 1;
    end

    always @(negedge mdc) mdio_i = phy_bit(cap_n);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_wr_sel = sel; reg_wr_data = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] sel, output logic [31:0] val);
        @(negedge clk);
        reg_rd_sel = sel;
        #1 val = reg_rd_data;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            reg_rd_sel = 2'd0;
            #1;
            if (!reg_rd_data[0]) break;
        end
    endtask

    task automatic arm(input int pre);
        cap_n = 0;
        phy_pre = pre;
    endtask

    // compares captured bits against an expected frame body
    task automatic check_frame(input string tag, input int pre, input logic [31:0] exp_word,
                               input bit is_read);
        int bad;
        chk({tag, " length"}, cap_n, pre + 32);
        bad = 0;
        for (int i = 0; i < pre; i++) if (cap_o[i] !== 1'b1 || cap_oe[i] !== 1'b1) bad++;
        chk({tag, " preamble"}, bad, 0);
        bad = 0;
        for (int i = 0; i < 32; i++) begin
            if (!is_read || i < 14) begin
                if (cap_o[pre + i] !== exp_word[31 - i] || cap_oe[pre + i] !== 1'b1) bad++;
            end else if (cap_oe[pre + i] !== 1'b0) bad++;
        end
        chk({tag, " body"}, bad, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        read_reg(2'd0, v); chk("R1 status reset", v, 32'h0);
        read_reg(2'd1, v); chk("R1 control reset", v, 32'h0);
        read_reg(2'd2, v); chk("R1 data reset", v, 32'h0);
        chk("R2 mdc idle low", mdc, 1'b0);
        chk("R12 oe idle low", mdio_oe, 1'b0);
    endtask

    task automatic t_c22_write();
        logic [31:0] v;
        write_reg(2'd0, 32'h0000_0200);
        write_reg(2'd1, 32'h0000_00A3);
        read_reg(2'd1, v); chk("R1 control readback", v, 32'h0000_00A3);
        arm(32);
        write_reg(2'd2, 32'h0000_BEEF);
        read_reg(2'd0, v); chk("R9 busy in status", v[0], 1'b1);
        read_reg(2'd2, v); chk("R9 busy in data bit31", v, 32'h8000_BEEF);
        wait_idle();
        check_frame("R4 R6 c22 write", 32, {2'b01, 2'b01, 5'd5, 5'd3, 2'b10, 16'hBEEF}, 1'b0);
        chk("R2 period div2", 32'(rise_t[1] - rise_t[0]), 32'(4 * CLK_PERIOD));
        chk("R12 oe low after frame", mdio_oe, 1'b0);
        read_reg(2'd2, v); chk("R9 busy cleared", v, 32'h0000_BEEF);
    endtask

    task automatic t_c45_addr();
        logic [31:0] v;
        write_reg(2'd0, 32'h0000_0140);
        write_reg(2'd1, 32'h0000_0027);
        arm(32);
        write_reg(2'd3, 32'h0000_1234);
        wait_idle();
        check_frame("R5 c45 address", 32, {2'b00, 2'b00, 5'd1, 5'd7, 2'b10, 16'h1234}, 1'b0);
        chk("R2 period div1", 32'(rise_t[1] - rise_t[0]), 32'(2 * CLK_PERIOD));
        read_reg(2'd3, v); chk("R1 address readback", v, 32'h0000_1234);
    endtask

    task automatic t_c45_read_ok();
        logic [31:0] v;
        write_reg(2'd0, 32'h0000_0040);
        phy_on = 1'b1; phy_resp = 16'hA5C3;
        arm(32);
        write_reg(2'd1, 32'h0000_8027);
        wait_idle();
        check_frame("R7 c45 read", 32, {2'b00, 2'b11, 5'd1, 5'd7, 18'h0}, 1'b1);
        chk("R2 period div0", 32'(rise_t[1] - rise_t[0]), 32'(2 * CLK_PERIOD));
        read_reg(2'd2, v); chk("R7 read data", v, 32'h0000_A5C3);
        read_reg(2'd0, v); chk("R8 no error with PHY", v[1], 1'b0);
        read_reg(2'd1, v); chk("R1 read bit not stored", v, 32'h0000_0027);
    endtask

    task automatic t_c22_read_err();
        logic [31:0] v;
        write_reg(2'd0, 32'h0000_0100);
        phy_on = 1'b0;
        arm(0);
        write_reg(2'd1, 32'h0000_8441);
        wait_idle();
        check_frame("R3 R4 c22 read no preamble", 0, {2'b01, 2'b10, 5'd2, 5'd1, 18'h0}, 1'b1);
        read_reg(2'd0, v); chk("R8 error set", v[1], 1'b1);
        read_reg(2'd2, v); chk("R7 absent PHY data", v, 32'h0000_FFFF);
        arm(0);
        write_reg(2'd2, 32'h0000_0042);
        wait_idle();
        read_reg(2'd0, v); chk("R8 error sticky over write", v[1], 1'b1);
        phy_on = 1'b1; phy_resp = 16'h3C3C;
        arm(0);
        write_reg(2'd1, 32'h0000_8441);
        read_reg(2'd0, v); chk("R8 error cleared at read launch", v[1:0], 2'b01);
        wait_idle();
        read_reg(2'd2, v); chk("R7 c22 read data", v, 32'h0000_3C3C);
        read_reg(2'd0, v); chk("R8 error stays clear", v[1], 1'b0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        write_reg(2'd0, 32'h0000_0100);
        write_reg(2'd1, 32'h0000_00A3);
        arm(32);
        write_reg(2'd2, 32'h0000_1111);
        write_reg(2'd2, 32'h0000_2222);
        write_reg(2'd1, 32'h0000_8000);
        write_reg(2'd0, 32'h0000_0F40);
        write_reg(2'd3, 32'h0000_7777);
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R10 single frame", cap_n, 64);
        read_reg(2'd2, v); chk("R10 data kept", v, 32'h0000_1111);
        read_reg(2'd0, v); chk("R10 status kept", v, 32'h0000_0100);
        read_reg(2'd1, v); chk("R10 control kept", v, 32'h0000_00A3);
        read_reg(2'd3, v); chk("R10 address kept", v, 32'h0000_1234);
    endtask

    task automatic t_addr_c22();
        logic [31:0] v;
        arm(32);
        write_reg(2'd3, 32'h0000_5555);
        read_reg(2'd0, v); chk("R11 no busy", v[0], 1'b0);
        repeat (20) @(negedge clk);
        chk("R11 no mdc activity", cap_n, 0);
        read_reg(2'd3, v); chk("R11 address stored", v, 32'h0000_5555);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_c22_write();
        t_c45_addr();
        t_c45_read_ok();
        t_c22_read_err();
        t_busy_ignore();
        t_addr_c22();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule